// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a synchronous serial slave that lets a host read and write an internal bank of byte-wide registers addressed by an 8-bit index. The host frames each transfer by pulling the active-low select low. It then clocks bytes in on the serial input, least significant bit first. The slave captures input bits on the rising edge of the serial clock and changes its output bit after the falling edge. The first byte of every frame is the register index. Every byte after it is data.

A separate direction input picks the transfer type. When it is high, the frame is a read: the output line is enabled and carries zero filler bits during the index byte, then the contents of the addressed registers. When it is low, the frame is a write: the output stays disabled and each complete data byte is stored. After the index byte, the slave drives an active-low wait flag for a fixed number of system clocks while it performs the internal access. The host holds the serial clock idle until the flag returns high. Within one frame, each completed data byte advances the index by one, so a burst touches consecutive registers. The index wraps from the top of the space back to zero.

All serial inputs pass through synchronizers into the system clock domain. The serial clock must therefore be several times slower than the system clock.

Top module: `sreg_slave`

## Requirements
- R1: After reset every register reads as 0x00, `wait_n` is high and `sdo_oe` is low.
- R2: In a write frame, the first eight `sdi` bits after `cs_n` falls, sampled on `sclk` rising edges with bit 0 first, form the register index. Each later group of eight bits, also bit 0 first, is stored into the indexed register.
- R3: In a read frame, each data byte is the content of the indexed register, presented on `sdo` bit 0 first. Each new bit appears after an `sclk` falling edge and is valid before the next rising edge.
- R4: During the index byte of a read frame, and while `wait_n` is low, `sdo` carries 0.
- R5: Once the eighth index bit has been captured, `wait_n` goes low for exactly ACCESS_CYCLES system clocks (6 by default) and then returns high before the first data bit is needed.
- R6: Within one frame, the index advances by one after each complete data byte, in both reads and writes, and wraps from 0xFF to 0x00.
- R7: A byte left incomplete when `cs_n` rises is discarded. No register changes, and the next frame starts again with an index byte.
- R8: `sdo_oe` is high only while `cs_n` is low and `rw` is high. It is low during write frames and between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial shift clock from the host |
| sdi | input | 1 | Serial data from the host, bit 0 first |
| rw | input | 1 | Frame direction: 1 read, 0 write |
| sdo | output | 1 | Serial data to the host, bit 0 first |
| sdo_oe | output | 1 | Output enable for `sdo` (high = driven) |
| wait_n | output | 1 | Active-low request to pause after the index byte |

## Verification
The hardest situation to reach is a byte boundary inside a read burst. On the eighth rising edge, the next register must be loaded into the shifter, and the falling edge that follows must not shift it. The same boundary must also carry the index across 0xFF to 0x00. The stimulus reaches this with multi-byte bursts that start at 0xFE, checked byte by byte against a shadow copy of the register bank. Frames cut short in the middle of a data byte or an index byte test the discard rule: the affected register is read back in a fresh frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } sreg_state_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int ACCESS_CYCLES = 6,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    input  logic rw,
    output logic sdo,
    output logic sdo_oe,
    output logic wait_n
);

    localparam int SHIFT_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W   = (SHIFT_W > 2) ? $clog2(SHIFT_W) : 1;
    localparam int WAIT_W  = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES + 1) : 1;

    typedef struct packed {
        sreg_state_e        state;
        logic               sclk_prev;
        logic [CNT_W-1:0]   bit_cnt;
        logic [ADDR_W-1:0]  addr;
        logic [SHIFT_W-2:0] rx;
        logic [DATA_W-1:0]  tx;
        logic [WAIT_W-1:0]  wcnt;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:     ST_IDLE,
        sclk_prev: 1'b0,
        bit_cnt:   '0,
        addr:      '0,
        rx:        '0,
        tx:        '0,
        wcnt:      '0
    };

    // synchronized inputs: {cs_n, sclk, sdi, rw}
    logic [3:0] sync_q;

    sreg_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1000)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, sdi, rw}),
        .q     (sync_q)
    );

    regs_t r_q, r_d;

    logic cs_act, sclk_s, sdi_s, rd_mode;
    logic sclk_rise, sclk_fall;
    logic [SHIFT_W-1:0] rx_shift;

    logic              reg_we;
    logic [ADDR_W-1:0] reg_waddr;
    logic [DATA_W-1:0] reg_wdata;
    logic [ADDR_W-1:0] reg_raddr;
    logic [DATA_W-1:0] reg_rdata;

    assign cs_act    = ~sync_q[3];
    assign sclk_s    = sync_q[2];
    assign sdi_s     = sync_q[1];
    assign rd_mode   = sync_q[0];
    assign sclk_rise = sclk_s & ~r_q.sclk_prev;
    assign sclk_fall = ~sclk_s & r_q.sclk_prev;
    assign rx_shift  = {sdi_s, r_q.rx};

    // look-ahead read port: first byte at the end of the wait, next byte at a byte boundary
    assign reg_raddr = (r_q.state == ST_WAIT) ? r_q.addr : r_q.addr + ADDR_W'(1);

    sreg_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata)
    );

    always_comb begin
        r_d           = r_q;
        r_d.sclk_prev = sclk_s;
        reg_we        = 1'b0;
        reg_waddr     = r_q.addr;
        reg_wdata     = rx_shift[SHIFT_W-1 -: DATA_W];

        if (!cs_act) begin
            r_d.state   = ST_IDLE;
            r_d.bit_cnt = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.state   = ST_ADDR;
                    r_d.bit_cnt = '0;
                end
                ST_ADDR: begin
                    if (sclk_rise) begin
                        r_d.rx = rx_shift[SHIFT_W-1:1];
                        if (r_q.bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            r_d.addr    = rx_shift[SHIFT_W-1 -: ADDR_W];
                            r_d.bit_cnt = '0;
                            r_d.wcnt    = WAIT_W'(ACCESS_CYCLES - 1);
                            r_d.state   = ST_WAIT;
                        end else begin
                            r_d.bit_cnt = r_q.bit_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (r_q.wcnt == '0) begin
                        r_d.state = ST_DATA;
                        r_d.tx    = reg_rdata;
                    end else begin
                        r_d.wcnt = r_q.wcnt - WAIT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (sclk_rise) begin
                        r_d.rx = rx_shift[SHIFT_W-1:1];
                        if (r_q.bit_cnt == CNT_W'(DATA_W - 1)) begin
                            r_d.bit_cnt = '0;
                            r_d.addr    = r_q.addr + ADDR_W'(1);
                            if (rd_mode) begin
                                r_d.tx = reg_rdata;
                            end else begin
                                reg_we = 1'b1;
                            end
                        end else begin
                            r_d.bit_cnt = r_q.bit_cnt + CNT_W'(1);
                        end
                    end else if (sclk_fall && rd_mode && r_q.bit_cnt != '0) begin
                        r_d.tx = r_q.tx >> 1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign sdo_oe = cs_act & rd_mode;
    assign sdo    = (r_q.state == ST_DATA && rd_mode) ? r_q.tx[0] : 1'b0;
    assign wait_n = (r_q.state != ST_WAIT);

endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk #(
    parameter int ACCESS_CYCLES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic wait_n,
    input logic sdo,
    input logic sdo_oe,
    input logic reg_we,
    input logic cs_act
);

    localparam int LOW_W = $clog2(ACCESS_CYCLES + 2);

    logic [LOW_W-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        low_cnt_q <= '0;
        else if (wait_n)                   low_cnt_q <= '0;
        else if (low_cnt_q != '1)          low_cnt_q <= low_cnt_q + LOW_W'(1);
    end

    AST_WAIT_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_n) |-> low_cnt_q == LOW_W'(ACCESS_CYCLES));     // R5

    AST_WAIT_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> low_cnt_q < LOW_W'(ACCESS_CYCLES));            // R5

    AST_WAIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> $past(cs_act));                          // R5

    AST_WAIT_FILLER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> !sdo);                                         // R4

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !reg_we);                                      // R7

    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !sdo_oe);                                       // R8

endmodule

bind sreg_slave sreg_slave_chk #(
    .ACCESS_CYCLES (ACCESS_CYCLES)
) i_sreg_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wait_n (wait_n),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .reg_we (reg_we),
    .cs_act (cs_act)
);

// File: tb/test_sreg_slave.sv
module test_sreg_slave;

    localparam int HALF = 8;
    localparam int ACC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic rw = 1'b0;
    logic sdo, sdo_oe, wait_n;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] shadow [256];
    logic [7:0] got_byte;
    event       got_ev;

    int low_run = 0;
    int last_low = 0;

    always #10 clk = ~clk;

    sreg_slave #(
        .ACCESS_CYCLES (ACC)
    ) i_sreg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .rw     (rw),
        .sdo    (sdo),
        .sdo_oe (sdo_oe),
        .wait_n (wait_n)
    );

    // measure every low pulse of wait_n in system clocks
    always @(negedge clk) begin
        if (!wait_n) low_run++;
        else if (low_run != 0) begin
            last_low = low_run;
            low_run  = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R3: got %0h expected <none>", got_byte);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (got_byte !== e.val) begin
                    failures++;
                    $display("FAIL %s: got %0h expected %0h", e.tag, got_byte, e.val);
                end
            end
        end
    end

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic open_frame(input logic dir);
        rw = dir;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 idle oe", sdo_oe, 1'b0);
    endtask

    task automatic handshake();
        repeat (6) @(negedge clk);
        check("R5 wait released", wait_n, 1'b1);
        check("R5 wait length", last_low, ACC);
    endtask

    task automatic write_burst(input logic [7:0] a, input logic [7:0] d [4], input int n);
        logic [7:0] rx;
        open_frame(1'b0);
        shift_bits(a, 8, rx);
        handshake();
        check("R8 write oe", sdo_oe, 1'b0);
        for (int k = 0; k < n; k++) begin
            shift_bits(d[k], 8, rx);
            shadow[8'(a + k)] = d[k];
        end
        close_frame();
    endtask

    task automatic read_burst(input logic [7:0] a, input int n, input string tag);
        logic [7:0] rx;
        open_frame(1'b1);
        check("R8 read oe", sdo_oe, 1'b1);
        shift_bits(a, 8, rx);
        check("R4 filler bits", rx, 8'h00);
        handshake();
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.val = shadow[8'(a + k)];
            e.tag = tag;
            exp_q.push_back(e);
            shift_bits(8'h00, 8, rx);
            got_byte = rx;
            -> got_ev;
            @(negedge clk);
        end
        close_frame();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d [4];
        logic [7:0] rx;
        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 wait_n", wait_n, 1'b1);
        check("R1 sdo_oe", sdo_oe, 1'b0);
        read_burst(8'h10, 1, "R1");
        read_burst(8'hC3, 1, "R1");

        // R2 / R6: write burst, read back as burst and singly
        d = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
        write_burst(8'h10, d, 4);
        read_burst(8'h10, 4, "R6");
        read_burst(8'h12, 1, "R3");
        read_burst(8'h13, 1, "R2");

        // R3: single-bit and alternating patterns
        d = '{8'h01, 8'h80, 8'h55, 8'hAA};
        write_burst(8'h40, d, 4);
        read_burst(8'h40, 1, "R3");
        read_burst(8'h41, 3, "R3");

        // R6: wrap from 0xFF to 0x00
        d = '{8'h11, 8'h22, 8'h33, 8'h00};
        write_burst(8'hFE, d, 3);
        read_burst(8'hFE, 3, "R6");
        read_burst(8'h00, 1, "R6");

        // R7: data byte cut short leaves the register unchanged
        d = '{8'h5A, 8'h00, 8'h00, 8'h00};
        write_burst(8'h20, d, 1);
        open_frame(1'b0);
        shift_bits(8'h20, 8, rx);
        handshake();
        shift_bits(8'hFF, 5, rx);
        close_frame();
        read_burst(8'h20, 1, "R7");

        // R7: second data byte of a burst cut short, first byte still lands
        open_frame(1'b0);
        shift_bits(8'h30, 8, rx);
        handshake();
        shift_bits(8'hC7, 8, rx);
        shadow[8'h30] = 8'hC7;
        shift_bits(8'hFF, 6, rx);
        close_frame();
        read_burst(8'h30, 2, "R7");

        // R7: index byte cut short, next frame starts cleanly
        open_frame(1'b0);
        shift_bits(8'h55, 3, rx);
        close_frame();
        read_burst(8'h11, 1, "R7");

        repeat (20) @(negedge clk);
        check("R7 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule